// File: doc/BRIEF.md
# Two-Resource Event Combiner

This block turns a programmable event word into a one-bit event, once per clock, for each of several channels. Each channel looks at the same shared set of resource lines:

- hits from single address comparators,
- hits from comparator-pair ranges,
- external inputs,
- a resource that is always true.

The event word names two of these resources, A and B, and a three-bit Boolean function that combines them. The result is registered. One channel instance serves each consumer: the trigger, trace-enable, view-data, counter and external-output logic.

Because constants are also written as an event word, no separate mode is needed. "Always" is the true resource passed straight through, and "never" is the same resource inverted. A local trigger can be widened to a cross-core trigger. The trigger word keeps its A selector, sets B to an external input, and sets the function to A OR B.

Top module: `evt_combiner`

## Requirements
- R1: Each channel's 17-bit event word holds the A selector in bits 6:0, the B selector in bits 13:7 and the function code in bits 16:14.
- R2: Resource code 0x6F is always true, so word 0x0006F gives a constant 1 and word 0x0406F a constant 0.
- R3: Resource codes 0x00 to 0x07 select single address comparator hits 0 to 7.
- R4: Resource codes 0x10 to 0x13 select comparator-pair range hits 0 to 3.
- R5: Resource codes 0x60 to 0x63 select external inputs 0 to 3.
- R6: Every other resource code reads as false, whatever the inputs are.
- R7: The function codes are: 0 gives A, 1 gives NOT A, 2 gives A AND B, 3 gives NOT A AND B, 4 gives NOT A AND NOT B, 5 gives A OR B, 6 gives NOT A OR B, and 7 gives NOT (A AND B).
- R8: A channel's output reflects the word and the resource inputs sampled at the previous rising clock edge. The output does not change between edges.
- R9: A synchronous active-high reset drives all event outputs to 0 and holds them there while it is asserted.
- R10: Channels are independent. Each channel evaluates its own word against the shared resources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| event_words | input | NUM_EVT*17 | Event word per channel; channel k occupies bits 17k+16:17k |
| addr_hit | input | N_ADDR | Single address comparator hits |
| range_hit | input | N_RANGE | Comparator-pair range hits |
| ext_in | input | N_EXT | External inputs |
| event_out | output | NUM_EVT | Registered event per channel |

## Verification
The hardest case to reach from the ports is a code in one of the unused gaps between the resource windows, placed in the B field. When B is combined with a true or false A, any wrong window bound or field offset can stay hidden. The stimulus therefore sweeps all 128 codes through both selector fields under four input patterns, including all ones. On each channel the partner resource is pinned to true or to an unused (false) code, so every decoded line shows up directly at the output. A second sweep drives every function code with every A/B pairing, and rotates the function across channels so that each channel sees a different function in the same cycle.

// File: rtl/evt_combiner_pkg.sv
package evt_combiner_pkg;

    localparam int SEL_W     = 7;
    localparam int FN_W      = 3;
    localparam int WORD_W    = 2 * SEL_W + FN_W;
    localparam int RES_SPACE = 1 << SEL_W;

    typedef logic [SEL_W-1:0] res_code_t;

    // Base codes of the resource windows; their values are decoded by software-built words.
    localparam res_code_t CODE_ADDR_BASE  = 7'h00;
    localparam res_code_t CODE_RANGE_BASE = 7'h10;
    localparam res_code_t CODE_EXT_BASE   = 7'h60;
    localparam res_code_t CODE_TRUE       = 7'h6F;

    typedef enum logic [FN_W-1:0] {
        FN_A         = 3'd0,
        FN_NOT_A     = 3'd1,
        FN_A_AND_B   = 3'd2,
        FN_NA_AND_B  = 3'd3,
        FN_NA_AND_NB = 3'd4,
        FN_A_OR_B    = 3'd5,
        FN_NA_OR_B   = 3'd6,
        FN_NAND      = 3'd7
    } evt_fn_e;

    // Packed MSB first: function in 16:14, B in 13:7, A in 6:0.
    typedef struct packed {
        evt_fn_e   fn;
        res_code_t sel_b;
        res_code_t sel_a;
    } evt_word_t;

    function automatic logic evt_apply(evt_fn_e fn, logic a, logic b);
        logic y;
        case (fn)
            FN_A:         y = a;
            FN_NOT_A:     y = ~a;
            FN_A_AND_B:   y = a & b;
            FN_NA_AND_B:  y = ~a & b;
            FN_NA_AND_NB: y = ~a & ~b;
            FN_A_OR_B:    y = a | b;
            FN_NA_OR_B:   y = ~a | b;
            default:      y = ~(a & b);
        endcase
        return y;
    endfunction

    function automatic logic code_in_window(res_code_t code, res_code_t base, int count);
        return (int'(code) >= int'(base)) && (int'(code) < int'(base) + count);
    endfunction

    // True when a code maps to some resource line that can be non-zero.
    function automatic logic code_is_live(res_code_t code, int n_addr, int n_range, int n_ext);
        return code_in_window(code, CODE_ADDR_BASE, n_addr)
            || code_in_window(code, CODE_RANGE_BASE, n_range)
            || code_in_window(code, CODE_EXT_BASE, n_ext)
            || (code == CODE_TRUE);
    endfunction

endpackage

// File: rtl/evt_resource_bank.sv
module evt_resource_bank
    import evt_combiner_pkg::*;
#(
    parameter int N_ADDR  = 8,
    parameter int N_RANGE = 4,
    parameter int N_EXT   = 4
) (
    input  logic [N_ADDR-1:0]    addr_hit,
    input  logic [N_RANGE-1:0]   range_hit,
    input  logic [N_EXT-1:0]     ext_in,
    output logic [RES_SPACE-1:0] res_lines
);

    localparam int ADDR_LO  = int'(CODE_ADDR_BASE);
    localparam int RANGE_LO = int'(CODE_RANGE_BASE);
    localparam int EXT_LO   = int'(CODE_EXT_BASE);
    localparam int TRUE_IX  = int'(CODE_TRUE);

    // One line per resource code; codes with no source are tied low.
    for (genvar g = 0; g < RES_SPACE; g++) begin : g_line
        if (g >= ADDR_LO && g < ADDR_LO + N_ADDR) begin : g_addr
            assign res_lines[g] = addr_hit[g - ADDR_LO];
        end else if (g >= RANGE_LO && g < RANGE_LO + N_RANGE) begin : g_range
            assign res_lines[g] = range_hit[g - RANGE_LO];
        end else if (g >= EXT_LO && g < EXT_LO + N_EXT) begin : g_ext
            assign res_lines[g] = ext_in[g - EXT_LO];
        end else if (g == TRUE_IX) begin : g_true
            assign res_lines[g] = 1'b1;
        end else begin : g_none
            assign res_lines[g] = 1'b0;
        end
    end

endmodule

// File: rtl/evt_func_unit.sv
module evt_func_unit
    import evt_combiner_pkg::*;
(
    input  evt_fn_e fn,
    input  logic    res_a,
    input  logic    res_b,
    output logic    result
);

    always_comb begin
        result = evt_apply(fn, res_a, res_b);
    end

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_combiner_pkg::*;
#(
    parameter int N_ADDR  = 8,
    parameter int N_RANGE = 4,
    parameter int N_EXT   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  evt_word_t            word,
    input  logic [RES_SPACE-1:0] res_lines,
    output logic                 ev
);

    logic hit_a;
    logic hit_b;
    logic comb_ev;
    logic ev_q;
    logic run_q;

    assign hit_a = res_lines[word.sel_a];
    assign hit_b = res_lines[word.sel_b];

    evt_func_unit i_func (
        .fn     (word.fn),
        .res_a  (hit_a),
        .res_b  (hit_b),
        .result (comb_ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q  <= 1'b0;
            run_q <= 1'b0;
        end else begin
            ev_q  <= comb_ev;
            run_q <= 1'b1;
        end
    end

    assign ev = ev_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !ev_q); // R9

    AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (rst)
        (word == evt_word_t'(17'h0006F)) |=> ev_q); // R2

    AST_ALWAYS_FALSE: assert property (@(posedge clk) disable iff (rst)
        (word == evt_word_t'(17'h0406F)) |=> !ev_q); // R2

    AST_UNUSED_FALSE: assert property (@(posedge clk) disable iff (rst)
        (word.fn == FN_A && !code_is_live(word.sel_a, N_ADDR, N_RANGE, N_EXT)) |=> !ev_q); // R6

    AST_FOLLOW_A: assert property (@(posedge clk) disable iff (rst)
        (word.fn == FN_A) |=> (ev_q == $past(hit_a))); // R8

    AST_OR_TRUE: assert property (@(posedge clk) disable iff (rst)
        (word.fn == FN_A_OR_B && word.sel_b == CODE_TRUE) |=> ev_q); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (run_q && $stable(word) && $stable(res_lines)) |=> $stable(ev_q)); // R8

endmodule

// File: rtl/evt_combiner.sv
module evt_combiner
    import evt_combiner_pkg::*;
#(
    parameter int NUM_EVT = 5,
    parameter int N_ADDR  = 8,
    parameter int N_RANGE = 4,
    parameter int N_EXT   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_EVT*WORD_W-1:0] event_words,
    input  logic [N_ADDR-1:0]         addr_hit,
    input  logic [N_RANGE-1:0]        range_hit,
    input  logic [N_EXT-1:0]          ext_in,
    output logic [NUM_EVT-1:0]        event_out
);

    logic [RES_SPACE-1:0] res_lines;

    evt_resource_bank #(
        .N_ADDR  (N_ADDR),
        .N_RANGE (N_RANGE),
        .N_EXT   (N_EXT)
    ) i_bank (
        .addr_hit  (addr_hit),
        .range_hit (range_hit),
        .ext_in    (ext_in),
        .res_lines (res_lines)
    );

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_chan
        evt_word_t word_k;
        assign word_k = evt_word_t'(event_words[k*WORD_W +: WORD_W]);

        evt_channel #(
            .N_ADDR  (N_ADDR),
            .N_RANGE (N_RANGE),
            .N_EXT   (N_EXT)
        ) i_chan (
            .clk       (clk),
            .rst       (rst),
            .word      (word_k),
            .res_lines (res_lines),
            .ev        (event_out[k])
        );
    end

endmodule

// File: tb/test_evt_combiner.sv
`timescale 1ns/1ps
module test_evt_combiner;

    localparam int NE = 5;
    localparam int NA = 8;
    localparam int NR = 4;
    localparam int NX = 4;
    localparam int WW = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NE*WW-1:0]  words = '0;
    logic [NA-1:0]     ah = '0;
    logic [NR-1:0]     rh = '0;
    logic [NX-1:0]     xh = '0;
    logic [NE-1:0]     ev;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    evt_combiner #(.NUM_EVT(NE), .N_ADDR(NA), .N_RANGE(NR), .N_EXT(NX)) i_evt_combiner (
        .clk(clk), .rst(rst), .event_words(words), .addr_hit(ah),
        .range_hit(rh), .ext_in(xh), .event_out(ev)
    );

    function automatic logic [WW-1:0] mk(int fn, int sb, int sa);
        return (WW'(fn) << 14) | (WW'(sb) << 7) | WW'(sa);
    endfunction

    function automatic logic model_res(int code);
        if (code < NA) return ah[code];
        if (code >= 16 && code < 16 + NR) return rh[code - 16];
        if (code >= 96 && code < 96 + NX) return xh[code - 96];
        return code == 111;
    endfunction

    function automatic logic model_fn(int fn, logic a, logic b);
        case (fn)
            0: return a;
            1: return !a;
            2: return a && b;
            3: return !a && b;
            4: return !a && !b;
            5: return a || b;
            6: return !a || b;
            default: return !(a && b);
        endcase
    endfunction

    function automatic string tag_for(int code);
        if (code < NA) return "R3";
        if (code >= 16 && code < 16 + NR) return "R4";
        if (code >= 96 && code < 96 + NX) return "R5";
        if (code == 111) return "R2";
        return "R6";
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic set_word(int k, logic [WW-1:0] w);
        words[k*WW +: WW] = w;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NE-1:0] exp_v;
        // Reset behaviour: constant-true words while reset held
        for (int k = 0; k < NE; k++) set_word(k, mk(0, 0, 111));
        repeat (2) @(negedge clk);
        for (int k = 0; k < NE; k++) chk("R9", ev[k], 1'b0);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NE; k++) chk("R2", ev[k], 1'b1);

        // Latency: new word reaches the output only after the next rising edge
        set_word(0, mk(1, 0, 111));
        @(negedge clk);
        chk("R2", ev[0], 1'b0);
        set_word(0, mk(0, 0, 111));
        #1 chk("R8", ev[0], 1'b0);
        @(negedge clk);
        chk("R8", ev[0], 1'b1);
        set_word(0, mk(0, 0, 3));
        ah = 8'h08;
        @(negedge clk);
        ah = 8'h00;
        #1 chk("R8", ev[0], 1'b1);
        @(negedge clk);
        chk("R8", ev[0], 1'b0);

        // Code sweep through A and B fields on separate channels
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 128; c++) begin
                case (p)
                    0: begin ah = 8'hA5; rh = 4'h6; xh = 4'h9; end
                    1: begin ah = 8'h5A; rh = 4'h9; xh = 4'h6; end
                    2: begin ah = 8'hFF; rh = 4'hF; xh = 4'hF; end
                    default: begin ah = 8'h00; rh = 4'h0; xh = 4'h0; end
                endcase
                set_word(0, mk(0, 127, c));
                set_word(1, mk(1, 127, c));
                set_word(2, mk(2, c, 111));
                set_word(3, mk(5, c, 127));
                set_word(4, mk(3, 111, c));
                exp_v[0] = model_res(c);
                exp_v[1] = !model_res(c);
                exp_v[2] = model_res(c);
                exp_v[3] = model_res(c);
                exp_v[4] = !model_res(c);
                @(negedge clk);
                chk(tag_for(c), ev[0], exp_v[0]);
                chk("R7", ev[1], exp_v[1]);
                chk("R1", ev[2], exp_v[2]);
                chk(tag_for(c), ev[3], exp_v[3]);
                chk("R10", ev[4], exp_v[4]);
            end
        end

        // Function sweep: every code with every A/B pairing, rotated across channels
        for (int f = 0; f < 8; f++) begin
            for (int ab = 0; ab < 4; ab++) begin
                for (int k = 0; k < NE; k++)
                    set_word(k, mk((f + k) % 8, ab[1] ? 111 : 127, ab[0] ? 111 : 127));
                @(negedge clk);
                for (int k = 0; k < NE; k++)
                    chk("R7", ev[k], model_fn((f + k) % 8, ab[0], ab[1]));
            end
        end

        // Reset in mid-run clears and holds outputs
        for (int k = 0; k < NE; k++) set_word(k, mk(0, 0, 111));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NE; k++) chk("R9", ev[k], 1'b0);
        @(negedge clk);
        for (int k = 0; k < NE; k++) chk("R9", ev[k], 1'b0);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NE; k++) chk("R2", ev[k], 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule